// File: doc/BRIEF.md
# Touch Panel Switch and Pen-Interrupt Controller

This block sits beside the conversion sequencer of a resistive touch-screen digitizer. Each time the sequencer latches a new command, it hands over a channel address, a reference-mode bit and two power bits. The block holds that configuration. From it, together with the acquisition and conversion phase strobes, it drives:
- enables for the four panel switch drivers (X+, X-, Y+, Y-)
- the converter input select and the reference pair select
- the battery-divider and diode-bias enables
- the internal reference power state
- an active-low pen interrupt

Between conversions the block either keeps the measuring drivers closed, so that repeated or settled conversions are possible, or arms pen detection. When pen detection is armed, the Y- driver is closed and a touch, seen through a synchronized detect input, pulls the interrupt low. During a measurement the interrupt is forced to a fixed level, chosen by the kind of channel being measured. Every output is a flop and is updated from the state and inputs of the previous cycle.

Top module: `touch_drive_ctl`

## Requirements
- R1: In single-ended mode (`cfg_single`=1) with `cfg_keep_on`=0, the drivers for a panel channel are closed only in cycles following an acquisition cycle, and all four are open after a conversion-only cycle. Driver vector {xp,xn,yp,yn}: address 1 gives 0011, addresses 3 and 4 give 0110, address 5 gives 1100, and every other address gives 0000.
- R2: In differential mode (`cfg_single`=0), a panel channel keeps its drivers closed through conversion cycles as well as acquisition cycles.
- R3: `in_sel` follows the latched address: 0 selects the diode (addresses 0 and 7), 1 selects the X+ node (addresses 1 and 3), 2 selects the battery divider (address 2), 3 selects the Y+ node (address 5), 4 selects the Y- node (address 4), and 5 selects the auxiliary input (address 6).
- R4: In differential mode on a panel channel, the positive reference select is 1 (Y+) for addresses 1, 3 and 4 and 2 (X+) for address 5. The negative reference select is 1 (Y-) for address 1 and 2 (X-) for addresses 3, 4 and 5. In every other case both selects are 0 (reference pin and ground).
- R5: `bat_div_en` is high only after acquisition cycles of address 2. `temp_bias_en` is high only after acquisition cycles of addresses 0 and 7.
- R6: With `cfg_keep_on`=1, a panel channel's drivers stay closed after acquisition, through conversion and afterwards. This lasts until a command with a different configuration is loaded or `chip_sel_n` goes high, which opens them on the next edge.
- R7: After `conv_done` with `cfg_keep_on`=0, the Y- driver is closed and `pen_irq_n` is the inverse of `pen_touch`, one cycle late. This armed state is also the reset state.
- R8: While pen detection is not armed, `pen_irq_n` is forced to 0 for panel channels (addresses 1, 3, 4, 5) and to 1 for all other addresses, whatever the value of `pen_touch`.
- R9: `vref_on` takes the value of `cfg_ref_pwr` on the edge that loads a command and changes at no other time. A rise of `chip_sel_n` does not change it.
- R10: After reset, `drv_yn`=1, the other drivers are 0, `pen_irq_n`=1 with no touch, `vref_on`=0, and both bias enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| cfg_load | input | 1 | One-cycle strobe that latches a new command |
| cfg_addr | input | 3 | Channel address |
| cfg_single | input | 1 | 1 = single-ended reference, 0 = differential |
| cfg_keep_on | input | 1 | 1 = keep the converter path up between conversions, 0 = arm pen detection |
| cfg_ref_pwr | input | 1 | Internal reference power request |
| acq_phase | input | 1 | High during acquisition cycles |
| conv_phase | input | 1 | High during conversion cycles |
| conv_done | input | 1 | Strobe marking the end of conversion |
| pen_touch | input | 1 | Synchronized touch detect, 1 = touched |
| drv_xp | output | 1 | X+ driver enable |
| drv_xn | output | 1 | X- driver enable |
| drv_yp | output | 1 | Y+ driver enable |
| drv_yn | output | 1 | Y- driver enable |
| in_sel | output | 3 | Converter input select |
| refp_sel | output | 2 | Positive reference select |
| refn_sel | output | 2 | Negative reference select |
| bat_div_en | output | 1 | Battery divider enable |
| temp_bias_en | output | 1 | Diode bias enable |
| vref_on | output | 1 | Internal reference powered |
| pen_irq_n | output | 1 | Pen interrupt, active low |

## Verification
The assertions assume the sequencer never raises `cfg_load` in the same cycle as `conv_done` or a phase strobe. They also assume it starts acquisition only in a cycle after the load. The stimulus keeps to this order: load, then acquisition, then conversion, then done, with one strobe per cycle. The only exception is the reload-while-holding case, where the load cycle has no phase strobe. Inputs change only on falling edges, so each registered response is sampled one edge after its cause.

// File: rtl/touch_drive_ctl.sv
module touch_drive_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_sel_n,
  input  logic       cfg_load,
  input  logic [2:0] cfg_addr,
  input  logic       cfg_single,
  input  logic       cfg_keep_on,
  input  logic       cfg_ref_pwr,
  input  logic       acq_phase,
  input  logic       conv_phase,
  input  logic       conv_done,
  input  logic       pen_touch,
  output logic       drv_xp,
  output logic       drv_xn,
  output logic       drv_yp,
  output logic       drv_yn,
  output logic [2:0] in_sel,
  output logic [1:0] refp_sel,
  output logic [1:0] refn_sel,
  output logic       bat_div_en,
  output logic       temp_bias_en,
  output logic       vref_on,
  output logic       pen_irq_n
);
  localparam logic [2:0] SEL_DIODE = 3'd0, SEL_XP = 3'd1, SEL_BAT = 3'd2,
                         SEL_YP = 3'd3, SEL_YN = 3'd4, SEL_AUX = 3'd5;

  logic [2:0] a_q;
  logic se_q, keep_q, ref_q, active_q, armed_q, hold_q;

  wire ch_y  = (a_q == 3'b001);
  wire ch_z1 = (a_q == 3'b011);
  wire ch_z2 = (a_q == 3'b100);
  wire ch_x  = (a_q == 3'b101);
  wire panel = ch_y | ch_z1 | ch_z2 | ch_x;

  wire cfg_change = cfg_load &&
    ({cfg_addr, cfg_single, cfg_keep_on, cfg_ref_pwr} != {a_q, se_q, keep_q, ref_q});
  wire win = panel && !chip_sel_n &&
    ((active_q && (acq_phase || (conv_phase && !se_q))) || hold_q);
  wire diff_ref = panel && !se_q;

  logic [2:0] sel_nx;
  always_comb begin
    case (a_q)
      3'b001, 3'b011: sel_nx = SEL_XP;
      3'b010:         sel_nx = SEL_BAT;
      3'b100:         sel_nx = SEL_YN;
      3'b101:         sel_nx = SEL_YP;
      3'b110:         sel_nx = SEL_AUX;
      default:        sel_nx = SEL_DIODE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; se_q <= 1'b0; keep_q <= 1'b0; ref_q <= 1'b0;
      active_q <= 1'b0; armed_q <= 1'b1; hold_q <= 1'b0;
    end else begin
      if (cfg_load) begin
        a_q <= cfg_addr; se_q <= cfg_single; keep_q <= cfg_keep_on; ref_q <= cfg_ref_pwr;
        active_q <= 1'b1; armed_q <= 1'b0;
      end else if (conv_done) begin
        active_q <= 1'b0; armed_q <= !keep_q;
      end
      if (chip_sel_n || cfg_change) hold_q <= 1'b0;
      else if (active_q && acq_phase && keep_q) hold_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {drv_xp, drv_xn, drv_yp, drv_yn} <= 4'b0001;
      in_sel <= SEL_DIODE; refp_sel <= '0; refn_sel <= '0;
      bat_div_en <= 1'b0; temp_bias_en <= 1'b0; pen_irq_n <= 1'b1;
    end else begin
      drv_xp <= win && ch_x;
      drv_xn <= win && (ch_x || ch_z1 || ch_z2);
      drv_yp <= win && (ch_y || ch_z1 || ch_z2);
      drv_yn <= (win && ch_y) || armed_q;
      in_sel <= sel_nx;
      refp_sel <= diff_ref ? (ch_x ? 2'd2 : 2'd1) : 2'd0;
      refn_sel <= diff_ref ? (ch_y ? 2'd1 : 2'd2) : 2'd0;
      bat_div_en <= active_q && acq_phase && (a_q == 3'b010);
      temp_bias_en <= active_q && acq_phase && (a_q == 3'b000 || a_q == 3'b111);
      pen_irq_n <= armed_q ? !pen_touch : !panel;
    end
  end

  assign vref_on = ref_q;

  p_se_conv_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && se_q && conv_phase && !acq_phase && !hold_q) |=>
      !(drv_xp || drv_xn || drv_yp || drv_yn));
  p_bias_after_acq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_div_en || temp_bias_en) |-> $past(acq_phase));
  p_hold_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && panel && !chip_sel_n) |=> (drv_xp || drv_yp));
  p_cs_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel_n |=> !(drv_xp || drv_xn || drv_yp));
  p_armed_yn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> drv_yn);
  p_pen_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && panel) |=> !pen_irq_n);
  p_vref_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(vref_on));
endmodule

// File: tb/touch_drive_ctl_tb.sv
module touch_drive_ctl_tb;
  logic clk = 0, rst_n = 0, chip_sel_n = 0, cfg_load = 0;
  logic [2:0] cfg_addr = 0;
  logic cfg_single = 1, cfg_keep_on = 0, cfg_ref_pwr = 0;
  logic acq_phase = 0, conv_phase = 0, conv_done = 0, pen_touch = 0;
  logic drv_xp, drv_xn, drv_yp, drv_yn, bat_div_en, temp_bias_en, vref_on, pen_irq_n;
  logic [2:0] in_sel;
  logic [1:0] refp_sel, refn_sel;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  touch_drive_ctl u_dut (.*);

  // {addr, single, drv{xp,xn,yp,yn}, in_sel, refp, refn, pen_irq_n, bat, temp}
  localparam logic [17:0] VEC [16] = '{
    {3'd0,1'b1,4'b0000,3'd0,2'd0,2'd0,1'b1,1'b0,1'b1},
    {3'd0,1'b0,4'b0000,3'd0,2'd0,2'd0,1'b1,1'b0,1'b1},
    {3'd1,1'b1,4'b0011,3'd1,2'd0,2'd0,1'b0,1'b0,1'b0},
    {3'd1,1'b0,4'b0011,3'd1,2'd1,2'd1,1'b0,1'b0,1'b0},
    {3'd2,1'b1,4'b0000,3'd2,2'd0,2'd0,1'b1,1'b1,1'b0},
    {3'd2,1'b0,4'b0000,3'd2,2'd0,2'd0,1'b1,1'b1,1'b0},
    {3'd3,1'b1,4'b0110,3'd1,2'd0,2'd0,1'b0,1'b0,1'b0},
    {3'd3,1'b0,4'b0110,3'd1,2'd1,2'd2,1'b0,1'b0,1'b0},
    {3'd4,1'b1,4'b0110,3'd4,2'd0,2'd0,1'b0,1'b0,1'b0},
    {3'd4,1'b0,4'b0110,3'd4,2'd1,2'd2,1'b0,1'b0,1'b0},
    {3'd5,1'b1,4'b1100,3'd3,2'd0,2'd0,1'b0,1'b0,1'b0},
    {3'd5,1'b0,4'b1100,3'd3,2'd2,2'd2,1'b0,1'b0,1'b0},
    {3'd6,1'b1,4'b0000,3'd5,2'd0,2'd0,1'b1,1'b0,1'b0},
    {3'd6,1'b0,4'b0000,3'd5,2'd0,2'd0,1'b1,1'b0,1'b0},
    {3'd7,1'b1,4'b0000,3'd0,2'd0,2'd0,1'b1,1'b0,1'b1},
    {3'd7,1'b0,4'b0000,3'd0,2'd0,2'd0,1'b1,1'b0,1'b1}
  };

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int drv4();
    return {drv_xp, drv_xn, drv_yp, drv_yn};
  endfunction

  task automatic load(input logic [2:0] a, input logic se, input logic keep, input logic rp);
    cfg_addr = a; cfg_single = se; cfg_keep_on = keep; cfg_ref_pwr = rp; cfg_load = 1;
    tick; cfg_load = 0;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    chk("R10 drivers", drv4(), 4'b0001);
    chk("R10 irq", pen_irq_n, 1);
    chk("R10 vref", vref_on, 0);
    chk("R10 bias", {bat_div_en, temp_bias_en}, 0);
    pen_touch = 1; tick;
    chk("R7 touch low", pen_irq_n, 0);
    pen_touch = 0; tick;
    chk("R7 release high", pen_irq_n, 1);

    pen_touch = 1;
    for (int i = 0; i < 16; i++) begin
      logic [17:0] v;
      v = VEC[i];
      load(v[17:15], v[14], 1'b0, 1'b0);
      acq_phase = 1; tick;
      chk("R1 acq drivers", drv4(), v[13:10]);
      chk("R3 in_sel", in_sel, v[9:7]);
      chk("R4 refp", refp_sel, v[6:5]);
      chk("R4 refn", refn_sel, v[4:3]);
      chk("R8 forced irq", pen_irq_n, v[2]);
      chk("R5 bat", bat_div_en, v[1]);
      chk("R5 temp", temp_bias_en, v[0]);
      acq_phase = 0; conv_phase = 1; tick;
      chk(v[14] ? "R1 conv open" : "R2 conv closed", drv4(), v[14] ? 0 : v[13:10]);
      chk("R5 bias off in conv", {bat_div_en, temp_bias_en}, 0);
      conv_phase = 0; conv_done = 1; tick;
      conv_done = 0; tick;
      chk("R7 armed drivers", drv4(), 4'b0001);
      chk("R7 armed irq", pen_irq_n, 0);
    end
    pen_touch = 0;

    load(3'd1, 1'b1, 1'b1, 1'b0);
    acq_phase = 1; tick;
    chk("R6 acq", drv4(), 4'b0011);
    acq_phase = 0; conv_phase = 1; tick;
    chk("R6 conv held", drv4(), 4'b0011);
    conv_phase = 0; conv_done = 1; tick;
    conv_done = 0; tick;
    chk("R6 after done", drv4(), 4'b0011);
    chk("R8 held irq forced", pen_irq_n, 0);
    load(3'd1, 1'b1, 1'b1, 1'b0);
    tick;
    chk("R6 same reload", drv4(), 4'b0011);
    chip_sel_n = 1; tick;
    chk("R6 cs high opens", drv4(), 4'b0000);
    chip_sel_n = 0; tick;
    chk("R6 stays open", drv4(), 4'b0000);

    load(3'd5, 1'b0, 1'b1, 1'b0);
    acq_phase = 1; tick;
    acq_phase = 0; tick; tick;
    chk("R6 X held", drv4(), 4'b1100);
    load(3'd1, 1'b0, 1'b1, 1'b0);
    tick;
    chk("R6 change opens", drv4(), 4'b0000);

    load(3'd2, 1'b1, 1'b0, 1'b1);
    chk("R9 vref on", vref_on, 1);
    chip_sel_n = 1; tick; tick;
    chk("R9 cs ignored", vref_on, 1);
    chip_sel_n = 0;
    load(3'd2, 1'b1, 1'b0, 1'b0);
    chk("R9 vref off", vref_on, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule